// File: doc/BRIEF.md
# Three-Channel TMDS Pixel Encoder

The block turns one RGB pixel per pixel clock into three 10-bit characters, one per colour lane, and sends each character out serially, least significant bit first. Lane 0 carries blue, lane 1 carries green and lane 2 carries red. While the active-video qualifier is high, each lane encodes its 8-bit colour. A first stage chains XOR or XNOR through the bits to cut transitions. A second stage may invert the low byte to keep the line DC-balanced.

While the qualifier is low, each lane sends one of four fixed control characters. The blue lane takes its two control bits from the sync inputs. The green and red lanes always send the control character for `00`. Each lane keeps its own running disparity, which is the count of ones sent minus the count of zeros sent. The encoder uses this count to choose between the two possible characters for a data word. The count returns to zero whenever a control character goes out.

The encoder registers its characters on the pixel clock. A serializer runs on a clock ten times faster. A one-cycle load strobe, which the caller asserts once every ten fast cycles while the characters are stable, copies the characters into the shift registers. A fourth lane, shifted in step with the data lanes, carries a pixel-rate clock pattern. Reset is synchronous and active low, and both clock domains sample it.

Top module: `tmds_link_encoder`

## Requirements
- R1: With `active_video` high, each lane's character equals the transition-minimized, DC-balanced encoding of its colour byte. The encoding depends on that lane's running disparity.
- R2: With `active_video` low, the blue lane sends the control character for {C1,C0} = {vsync,hsync}, written as bits [9:0]: 00 → 1101010100, 01 → 0010101011, 10 → 0101010100, 11 → 1010101011.
- R3: With `active_video` low, the green and red lanes always send 1101010100, whatever the sync and colour inputs are.
- R4: In a data character, bit 8 is 1 when XOR chaining was used and 0 when XNOR chaining was used. XNOR is chosen when the byte has more than four ones, or exactly four ones with bit 0 equal to 0.
- R5: Over the characters sent since the last control character, the running count of ones minus zeros is even and stays within −8 to +8.
- R6: After any control character, the next data character is encoded as if the running disparity were zero.
- R7: Each lane's character appears on `ser_data` one bit per fast cycle, bit 0 first. Bit 0 appears in the fast cycle after the load strobe, and the ten bits follow in consecutive fast cycles.
- R8: `clk_lane` shifts out the pattern 1111100000 with each load, bit 0 first: five low bits followed by five high bits.
- R9: While `rst_n` is low, `ser_data` and `clk_lane` are 0. After reset, the disparity of every lane starts from zero.
- R10: Every data character decodes back to the colour byte it was made from. To decode, undo the inversion marked by bit 9, then undo the XOR or XNOR chain marked by bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel-rate clock |
| ser_clk | input | 1 | Fast clock at ten times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| ser_load | input | 1 | One-cycle strobe in the fast domain that loads the next characters |
| blue | input | 8 | Blue colour component |
| green | input | 8 | Green colour component |
| red | input | 8 | Red colour component |
| hsync | input | 1 | Horizontal sync, control bit C0 of the blue lane |
| vsync | input | 1 | Vertical sync, control bit C1 of the blue lane |
| active_video | input | 1 | High: encode colour; low: encode control bits |
| ser_data | output | 3 | Serial data lanes: [0] blue, [1] green, [2] red |
| clk_lane | output | 1 | Serial pixel-rate clock lane |

## Verification
The bench targets the points where the disparity rules branch. These are a zero running count, a balanced byte, a count and a byte imbalance of the same sign, and the extreme bytes 0x00 and 0xFF, which swing the count to ±8 and back. A wrong branch shows up as a character that differs from the reference, or as a stream imbalance that drifts past ±8. The bench repeats one byte across a blanking gap to expose a count that survives a control character, and it toggles the sync bits to catch control bits that leak into green or red. Independently of the reference model, it decodes every received data character back to its byte and checks the XOR/XNOR marker bit against the byte's ones count. A reversed bit order, a lost bit or an off-by-one load would corrupt every decoded byte.

// File: rtl/tmds_link_pkg.sv
// Shared constants, types and helper functions for the TMDS pixel encoder.
// Assumes 8-bit colour components and 10-bit line characters.
package tmds_link_pkg;

    localparam int COLOR_W  = 8;
    localparam int CHAR_W   = COLOR_W + 2;
    localparam int NUM_CH   = 3;
    localparam int ONES_W   = $clog2(COLOR_W + 1);
    localparam int CNT_W    = ONES_W + 2;
    localparam int DISP_MAX = COLOR_W;

    typedef logic [CHAR_W-1:0]        char_t;
    typedef logic signed [CNT_W-1:0]  disp_t;

    localparam char_t CTRL_00     = 10'b1101010100;
    localparam char_t CTRL_01     = 10'b0010101011;
    localparam char_t CTRL_10     = 10'b0101010100;
    localparam char_t CTRL_11     = 10'b1010101011;
    localparam char_t CLK_PATTERN = 10'b1111100000;

    // Number of set bits in a colour-width word.
    function automatic logic [ONES_W-1:0] count_ones(input logic [COLOR_W-1:0] v);
        logic [ONES_W-1:0] n;
        n = '0;
        for (int i = 0; i < COLOR_W; i++) begin
            n = n + {{(ONES_W-1){1'b0}}, v[i]};
        end
        return n;
    endfunction

    // Control character selected by {C1,C0}.
    function automatic char_t ctrl_char(input logic [1:0] c);
        char_t r;
        case (c)
            2'b00:   r = CTRL_00;
            2'b01:   r = CTRL_01;
            2'b10:   r = CTRL_10;
            default: r = CTRL_11;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmds_xor_chain.sv
// First encode stage: chains XOR or XNOR through the colour bits to cut
// transitions, and marks the choice in the top bit (1 = XOR, 0 = XNOR).
// Purely combinational; assumes the caller registers the result.
module tmds_xor_chain
    import tmds_link_pkg::*;
(
    input  logic [COLOR_W-1:0] data_i,
    output logic [COLOR_W:0]   qm_o
);

    logic [ONES_W-1:0] ones;
    logic              use_xnor;
    logic [COLOR_W-1:0] chain;

    assign ones     = count_ones(data_i);
    assign use_xnor = (ones > ONES_W'(COLOR_W/2)) ||
                      ((ones == ONES_W'(COLOR_W/2)) && !data_i[0]);

    // Ripple the chosen XOR/XNOR from bit 0 upward.
    always_comb begin
        chain[0] = data_i[0];
        for (int i = 1; i < COLOR_W; i++) begin
            chain[i] = chain[i-1] ^ data_i[i] ^ use_xnor;
        end
    end

    assign qm_o = {~use_xnor, chain};

endmodule

// File: rtl/tmds_chan_enc.sv
// One colour lane: picks control or data encoding, applies the DC-balance
// inversion decision against the lane's running disparity, and registers the
// 10-bit character on the pixel clock. Assumes reset is synchronous, active low.
module tmds_chan_enc
    import tmds_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [1:0]         ctrl,
    input  logic [COLOR_W-1:0] color,
    output char_t              char_o,
    output disp_t              disp_o
);

    logic [COLOR_W:0]  qm;
    logic [ONES_W-1:0] n1;
    disp_t             diff;
    disp_t             bonus;
    disp_t             penalty;
    disp_t             disp_nxt;
    char_t             char_nxt;
    logic              same_sign;

    tmds_xor_chain u_chain (
        .data_i (color),
        .qm_o   (qm)
    );

    // Imbalance of the chained byte and the two marker-bit corrections.
    always_comb begin
        n1        = count_ones(qm[COLOR_W-1:0]);
        diff      = disp_t'({n1, 1'b0}) - disp_t'(COLOR_W);
        bonus     = qm[COLOR_W] ? disp_t'(2) : disp_t'(0);
        penalty   = qm[COLOR_W] ? disp_t'(0) : disp_t'(2);
        same_sign = ((disp_o > disp_t'(0)) && (diff > disp_t'(0))) ||
                    ((disp_o < disp_t'(0)) && (diff < disp_t'(0)));
    end

    // Select the next character and the matching disparity update.
    always_comb begin
        char_nxt = CTRL_00;
        disp_nxt = '0;
        if (!active) begin
            char_nxt = ctrl_char(ctrl);
            disp_nxt = '0;
        end else if ((disp_o == disp_t'(0)) || (diff == disp_t'(0))) begin
            char_nxt = {~qm[COLOR_W], qm[COLOR_W],
                        qm[COLOR_W] ? qm[COLOR_W-1:0] : ~qm[COLOR_W-1:0]};
            disp_nxt = qm[COLOR_W] ? (disp_o + diff) : (disp_o - diff);
        end else if (same_sign) begin
            char_nxt = {1'b1, qm[COLOR_W], ~qm[COLOR_W-1:0]};
            disp_nxt = disp_o + bonus - diff;
        end else begin
            char_nxt = {1'b0, qm[COLOR_W], qm[COLOR_W-1:0]};
            disp_nxt = disp_o - penalty + diff;
        end
    end

    // Register the character and the running disparity each pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_o <= '0;
            disp_o <= '0;
        end else begin
            char_o <= char_nxt;
            disp_o <= disp_nxt;
        end
    end

endmodule

// File: rtl/tmds_serializer.sv
// Parallel-to-serial shifter for a set of lanes on the fast clock. A load
// strobe copies all lanes at once; other cycles shift right, LSB out first.
// Assumes the parallel inputs are stable around the load strobe.
module tmds_serializer
    import tmds_link_pkg::*;
#(
    parameter int LANES = NUM_CH + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [LANES-1:0][CHAR_W-1:0] par_i,
    output logic [LANES-1:0]             ser_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        char_t shreg;

        // Load a fresh character or shift one bit toward the output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= '0;
            end else if (load_i) begin
                shreg <= par_i[l];
            end else begin
                shreg <= {1'b0, shreg[CHAR_W-1:1]};
            end
        end

        assign ser_o[l] = shreg[0];
    end

endmodule

// File: rtl/tmds_link_encoder.sv
// Top of the three-lane TMDS pixel encoder. Lane 0 blue (carries the syncs),
// lane 1 green, lane 2 red; a fourth serial lane carries the pixel clock.
// Assumes ser_clk runs at ten times pix_clk and ser_load pulses once per pixel.
module tmds_link_encoder
    import tmds_link_pkg::*;
(
    input  logic               pix_clk,
    input  logic               ser_clk,
    input  logic               rst_n,
    input  logic               ser_load,
    input  logic [COLOR_W-1:0] blue,
    input  logic [COLOR_W-1:0] green,
    input  logic [COLOR_W-1:0] red,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               active_video,
    output logic [NUM_CH-1:0]  ser_data,
    output logic               clk_lane
);

    localparam int LANES = NUM_CH + 1;

    logic [NUM_CH-1:0][COLOR_W-1:0] colors;
    logic [NUM_CH-1:0][CHAR_W-1:0]  char_all;
    logic [NUM_CH-1:0][CNT_W-1:0]   disp_all;
    logic [LANES-1:0][CHAR_W-1:0]   lanes;
    logic [LANES-1:0]               lane_bits;

    assign colors = {red, green, blue};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [1:0] ctrl;
        char_t      ch_char;
        disp_t      ch_disp;

        if (g == 0) begin : g_sync
            assign ctrl = {vsync, hsync};
        end else begin : g_zero
            assign ctrl = 2'b00;
        end

        tmds_chan_enc u_enc (
            .clk    (pix_clk),
            .rst_n  (rst_n),
            .active (active_video),
            .ctrl   (ctrl),
            .color  (colors[g]),
            .char_o (ch_char),
            .disp_o (ch_disp)
        );

        assign char_all[g] = ch_char;
        assign disp_all[g] = ch_disp;
    end

    assign lanes = {CLK_PATTERN, char_all};

    tmds_serializer #(
        .LANES (LANES)
    ) u_ser (
        .clk    (ser_clk),
        .rst_n  (rst_n),
        .load_i (ser_load),
        .par_i  (lanes),
        .ser_o  (lane_bits)
    );

    assign ser_data = lane_bits[NUM_CH-1:0];
    assign clk_lane = lane_bits[NUM_CH];

endmodule

// File: rtl/tmds_link_checker.sv
// Assertion checker for tmds_link_encoder, attached by bind. Observes the
// registered characters and disparities as well as the serial outputs.
module tmds_link_checker
    import tmds_link_pkg::*;
(
    input logic                          pix_clk,
    input logic                          ser_clk,
    input logic                          rst_n,
    input logic                          ser_load,
    input logic                          hsync,
    input logic                          vsync,
    input logic                          active_video,
    input logic [NUM_CH-1:0][CHAR_W-1:0] char_all,
    input logic [NUM_CH-1:0][CNT_W-1:0]  disp_all,
    input logic [NUM_CH-1:0]             ser_data,
    input logic                          clk_lane
);

    function automatic logic disp_ok(input logic [CNT_W-1:0] v);
        disp_t s;
        s = disp_t'(v);
        return (s <= disp_t'(DISP_MAX)) && (s >= -disp_t'(DISP_MAX)) && !v[0];
    endfunction

    AST_BLUE_CTRL_CHAR: assert property (@(posedge pix_clk) disable iff (!rst_n)
        !active_video |=> char_all[0] == ctrl_char($past({vsync, hsync}))); // R2

    AST_GR_CTRL_FIXED: assert property (@(posedge pix_clk) disable iff (!rst_n)
        !active_video |=> (char_all[1] == CTRL_00) && (char_all[2] == CTRL_00)); // R3

    AST_DISP_BOUND: assert property (@(posedge pix_clk) disable iff (!rst_n)
        disp_ok(disp_all[0]) && disp_ok(disp_all[1]) && disp_ok(disp_all[2])); // R5

    AST_CTRL_DISP_ZERO: assert property (@(posedge pix_clk) disable iff (!rst_n)
        !active_video |=> (disp_all[0] == '0) && (disp_all[1] == '0) && (disp_all[2] == '0)); // R6

    AST_LSB_FIRST: assert property (@(posedge ser_clk) disable iff (!rst_n)
        ser_load |=> ser_data == $past({char_all[2][0], char_all[1][0], char_all[0][0]})); // R7

    AST_CLK_LANE_START_LOW: assert property (@(posedge ser_clk) disable iff (!rst_n)
        ser_load |=> !clk_lane); // R8

endmodule

bind tmds_link_encoder tmds_link_checker u_checker (
    .pix_clk      (pix_clk),
    .ser_clk      (ser_clk),
    .rst_n        (rst_n),
    .ser_load     (ser_load),
    .hsync        (hsync),
    .vsync        (vsync),
    .active_video (active_video),
    .char_all     (char_all),
    .disp_all     (disp_all),
    .ser_data     (ser_data),
    .clk_lane     (clk_lane)
);

// File: tb/test_tmds_link_encoder.sv
// Self-checking bench: behavioural reference encoder, serial capture,
// decode-back, stream disparity and clock-lane pattern checks.
module test_tmds_link_encoder;

    logic       pix_clk = 1'b0;
    logic       ser_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_load = 1'b0;
    logic [7:0] blue = '0, green = '0, red = '0;
    logic       hsync = 1'b0, vsync = 1'b0, active_video = 1'b0;
    logic [2:0] ser_data;
    logic       clk_lane;

    tmds_link_encoder i_tmds_link_encoder (
        .pix_clk      (pix_clk),
        .ser_clk      (ser_clk),
        .rst_n        (rst_n),
        .ser_load     (ser_load),
        .blue         (blue),
        .green        (green),
        .red          (red),
        .hsync        (hsync),
        .vsync        (vsync),
        .active_video (active_video),
        .ser_data     (ser_data),
        .clk_lane     (clk_lane)
    );

    typedef struct packed {
        logic [2:0][9:0] chr;
        logic [2:0][7:0] col;
        logic            act;
    } exp_t;

    int         checks = 0;
    int         errors = 0;
    exp_t       exp_q[$];
    int         rd_ref[3];
    int         rd_rx[3];
    bit         after_ctrl[3];
    bit         collecting = 1'b0;
    int         bit_idx = 0;
    logic [2:0][9:0] rx_buf;
    logic [9:0] clk_buf;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int ones_of(input logic [9:0] v, input int w);
        int n;
        n = 0;
        for (int i = 0; i < w; i++) n += int'(v[i]);
        return n;
    endfunction

    // Behavioural encoder with an integer running disparity.
    function automatic logic [9:0] ref_char(input logic [7:0] d, inout int rd,
                                            input bit act, input logic [1:0] c);
        logic [8:0] qm;
        logic [9:0] o;
        int n, m1, m0;
        bit xn;
        if (!act) begin
            rd = 0;
            case (c)
                2'd0:    return 10'b1101010100;
                2'd1:    return 10'b0010101011;
                2'd2:    return 10'b0101010100;
                default: return 10'b1010101011;
            endcase
        end
        n  = ones_of({2'b00, d}, 8);
        xn = (n > 4) || (n == 4 && d[0] == 1'b0);
        qm[0] = d[0];
        for (int i = 1; i < 8; i++) qm[i] = xn ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
        qm[8] = !xn;
        m1 = ones_of({2'b00, qm[7:0]}, 8);
        m0 = 8 - m1;
        if (rd == 0 || m1 == m0) begin
            o  = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
            rd = rd + (qm[8] ? (m1 - m0) : (m0 - m1));
        end else if ((rd > 0 && m1 > m0) || (rd < 0 && m0 > m1)) begin
            o  = {1'b1, qm[8], ~qm[7:0]};
            rd = rd + 2 * int'(qm[8]) + m0 - m1;
        end else begin
            o  = {1'b0, qm[8], qm[7:0]};
            rd = rd - (qm[8] ? 0 : 2) + m1 - m0;
        end
        return o;
    endfunction

    function automatic logic [7:0] decode(input logic [9:0] c);
        logic [7:0] lo, d;
        lo   = c[9] ? ~c[7:0] : c[7:0];
        d[0] = lo[0];
        for (int i = 1; i < 8; i++) d[i] = c[8] ? (lo[i] ^ lo[i-1]) : ~(lo[i] ^ lo[i-1]);
        return d;
    endfunction

    task automatic finish_char();
        exp_t e;
        int   z, n;
        bit   xn;
        logic [9:0] zc;
        e = exp_q.pop_front();
        check(clk_buf == 10'b1111100000, "R8 clock lane pattern", clk_buf, 10'b1111100000);
        for (int ch = 0; ch < 3; ch++) begin
            if (e.act) begin
                check(rx_buf[ch] == e.chr[ch], $sformatf("R1 R7 data char lane %0d", ch), rx_buf[ch], e.chr[ch]);
                n  = ones_of({2'b00, e.col[ch]}, 8);
                xn = (n > 4) || (n == 4 && e.col[ch][0] == 1'b0);
                check(rx_buf[ch][8] == !xn, $sformatf("R4 chain marker lane %0d", ch), rx_buf[ch][8], !xn);
                check(decode(rx_buf[ch]) == e.col[ch], $sformatf("R10 decode lane %0d", ch), decode(rx_buf[ch]), e.col[ch]);
                rd_rx[ch] += 2 * ones_of(rx_buf[ch], 10) - 10;
                check(rd_rx[ch] <= 8 && rd_rx[ch] >= -8 && (rd_rx[ch] % 2) == 0,
                      $sformatf("R5 stream disparity lane %0d", ch), rd_rx[ch], 8);
                if (after_ctrl[ch]) begin
                    z  = 0;
                    zc = ref_char(e.col[ch], z, 1'b1, 2'b00);
                    check(rx_buf[ch] == zc, $sformatf("R6/R9 zero-count restart lane %0d", ch), rx_buf[ch], zc);
                    after_ctrl[ch] = 1'b0;
                end
            end else begin
                check(rx_buf[ch] == e.chr[ch], (ch == 0) ? "R2 blue control char" : "R3 fixed control char",
                      rx_buf[ch], e.chr[ch]);
                rd_rx[ch]      = 0;
                after_ctrl[ch] = 1'b1;
            end
        end
    endtask

    // One fast-clock cycle; pix_clk rises in phase 0 and falls in phase 5.
    task automatic ser_cycle(input int ph);
        ser_clk = 1'b1;
        #2;
        if (ph == 0) pix_clk = 1'b1;
        else if (ph == 5) pix_clk = 1'b0;
        #2;
        ser_clk = 1'b0;
        if (!rst_n && ph == 9) begin
            check(ser_data == 3'b000 && clk_lane == 1'b0, "R9 outputs low in reset",
                  {ser_data, clk_lane}, 0);
        end
        if (ph == 5 && !collecting && exp_q.size() > 0) begin
            collecting = 1'b1;
            bit_idx    = 0;
        end
        if (collecting) begin
            for (int ch = 0; ch < 3; ch++) rx_buf[ch][bit_idx] = ser_data[ch];
            clk_buf[bit_idx] = clk_lane;
            bit_idx++;
            if (bit_idx == 10) begin
                collecting = 1'b0;
                finish_char();
            end
        end
        ser_load = (ph == 4);
        #4;
    endtask

    task automatic pixel(input bit track, input bit act, input logic [7:0] b, input logic [7:0] g,
                         input logic [7:0] r, input bit hs, input bit vs);
        exp_t e;
        blue = b; green = g; red = r;
        hsync = hs; vsync = vs; active_video = act;
        if (track && rst_n) begin
            e.act    = act;
            e.col    = {r, g, b};
            e.chr[0] = ref_char(b, rd_ref[0], act, {vs, hs});
            e.chr[1] = ref_char(g, rd_ref[1], act, 2'b00);
            e.chr[2] = ref_char(r, rd_ref[2], act, 2'b00);
            exp_q.push_back(e);
        end
        for (int ph = 0; ph < 10; ph++) ser_cycle(ph);
    endtask

    task automatic clear_model();
        for (int ch = 0; ch < 3; ch++) begin
            rd_ref[ch]     = 0;
            rd_rx[ch]      = 0;
            after_ctrl[ch] = 1'b1;
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] dir [10];
        logic [7:0] v;
        dir = '{8'h00, 8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h01, 8'h80, 8'hFE};
        clear_model();
        rst_n = 1'b0;
        repeat (3) pixel(1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R2 R3: every sync combination during blanking, with random colours.
        for (int c = 0; c < 4; c++) begin
            repeat (2) pixel(1'b1, 1'b0, 8'($urandom), 8'($urandom), 8'($urandom), c[0], c[1]);
        end

        // R1 R4: directed bytes that hit each disparity branch.
        for (int i = 0; i < 10; i++) begin
            v = dir[i];
            pixel(1'b1, 1'b1, v, ~v, v ^ 8'h3C, 1'b0, 1'b0);
        end

        // R6: repeat a byte across a blanking gap.
        pixel(1'b1, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);
        pixel(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
        pixel(1'b1, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);
        pixel(1'b1, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0);

        // R5 R10: random stream with occasional blanking.
        for (int i = 0; i < 200; i++) begin
            pixel(1'b1, ($urandom % 8) != 0, 8'($urandom), 8'($urandom), 8'($urandom),
                  1'($urandom), 1'($urandom));
        end

        // R9: reset in the middle of a stream, then resume.
        pixel(1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (2) pixel(1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        clear_model();
        for (int i = 0; i < 60; i++) begin
            pixel(1'b1, ($urandom % 6) != 0, 8'($urandom), 8'($urandom), 8'($urandom),
                  1'($urandom), 1'($urandom));
        end
        pixel(1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule